// File: doc/BRIEF.md
# Flat Pointer Aperture Decoder

This block sits in front of the memory path of a shader core and handles one flat vector memory request per cycle. Each request carries a pointer, the offset of its last byte, a flag that says whether it came from a compute dispatch, and the process's addressing-mode bits. The block first works out the addressing mode. It then compares the pointer against four programmed windows: a window mapped to page-table virtual memory, a spare window that only changes the memory type, a shared-memory window and a private-scratch window. It reports where the request goes, a compressed 49-bit address (a translation-path bit plus a 48-bit virtual address), a memory-type selector and a memory-violation flag.

The aperture registers are loaded through a plain write port. Both ends of the request path use valid/ready. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its result appears on the next cycle and stays unchanged while `rsp_ready` is low. `req_ready` is high whenever the output stage is empty or is being drained in the same cycle, so the block runs at one request per cycle when there is no back-pressure.

Top module: `flat_aperture_decoder`

## Requirements
- R1: The mode is wide-translated (64-bit pointers, default ATC=1) when `req_compute`=1, `req_data_atc`=1 and `req_ptr32`=0. It is narrow (32-bit pointers, default ATC=1) when all three are 1. In every other case, including any request with `req_compute`=0, it is VM-default (64-bit pointers, default ATC=0) and `req_ptr32` is ignored.
- R2: `cfg_addr` selects the register that `cfg_wdata` (pointer bits 63:16) is written to: 0 = VM window base, 1 = VM window limit, 2 = spare window base, 3 = spare window limit, 4 = shared base, 5 = private base. Writes to 6 and 7 change nothing. Effective base = {bits 63:16, 16'h0000} and effective limit = {bits 63:16, 16'hFFFF}, and both bounds are inclusive. A VM or spare window whose effective base is above its limit is empty. After reset both bases are all ones and every other register is zero, so no window is active.
- R3: In the two 64-bit modes, a pointer whose bits 63:47 are neither all zero nor all one lies in the hole. Unless it hits the shared or private window, it is classified as hole, takes the default fields, and sets `rsp_viol`. The hole test ranks above the VM and spare windows.
- R4: A VM-window hit gives `rsp_route`=0, `rsp_atc`=0 and `rsp_vaddr` = (pointer − effective VM base) bits 47:0.
- R5: A request that hits no window takes the default space: `rsp_route`=0, `rsp_vaddr` = pointer bits 47:0, and `rsp_atc`=1 in the two translated modes or 0 in VM-default mode.
- R6: In the two 64-bit modes, a spare-window hit gives `rsp_mtype`=MTYPE_ALT. Every other request gives MTYPE_DFLT. In narrow mode the spare window is never tested. A spare hit otherwise behaves like the default space.
- R7: The region of the last byte (pointer + `req_last_ofs`) is computed with the same rules. If it differs from the region of the first byte, or if the first byte is in the hole, `rsp_viol` is 1.
- R8: In narrow mode only pointer bits 31:0 are used, and they are zero-extended. A shared window is active when its base bits 31:16 are nonzero and matches pointer bits 31:16 exactly (a 64 KB window). The private window follows the same rule. The VM window is compared against the zero-extended pointer.
- R9: In the 64-bit modes, a shared or private window is active when its base bits 63:32 are nonzero and covers the 4 GB whose bits 63:32 are equal to them. A shared hit gives `rsp_route`=1 and a private hit gives `rsp_route`=2, both with `rsp_atc`=0 and `rsp_vaddr` = offset from the window's effective base.
- R10: A result appears one cycle after acceptance and holds steady while `rsp_valid`=1 and `rsp_ready`=0. `req_ready` = !rsp_valid || rsp_ready. After reset, `rsp_valid`=0.
- R11: `cfg_err` becomes 1 one cycle after any two active windows overlap (shared and private tested as their 4 GB 64-bit windows). It stays 1 until reset. When windows overlap, hits are resolved with Shared ranked first, then Private, then VM, then spare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 48 | Pointer bits 63:16 to store |
| cfg_err | output | 1 | Sticky window-overlap flag |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_ptr | input | 64 | Flat pointer |
| req_last_ofs | input | OFS_W | Offset of the last byte from the pointer |
| req_compute | input | 1 | 1 = compute dispatch, 0 = draw |
| req_data_atc | input | 1 | Process translated-default bit |
| req_ptr32 | input | 1 | Process 32-bit pointer bit |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_route | output | 2 | 0 global, 1 shared, 2 private |
| rsp_atc | output | 1 | Translation-path bit |
| rsp_vaddr | output | 48 | Compressed virtual address |
| rsp_mtype | output | MT_W | Memory-type selector |
| rsp_viol | output | 1 | Memory violation |

## Verification
The assertions assume that the request fields stay constant while `req_valid` is high and `req_ready` is low, that reset lasts at least one clock, and that no register write happens in the same cycle whose acceptance is being checked against the new value. The stimulus meets these assumptions in three ways. It changes request fields only after a handshake, it holds a write strobe for exactly one cycle, and its reference model applies each write only after classifying the requests accepted on that same edge. Random back-pressure on `rsp_ready` exercises the stall-hold rule, and the overlap test runs last because the flag it sets is sticky.

// File: rtl/fad_pkg.sv
package fad_pkg;
  localparam int PTR_W    = 64;  // flat pointer width
  localparam int VA_W     = 48;  // compressed virtual address width
  localparam int GRAN_W   = 16;  // aperture granule (64 KB)
  localparam int WIN_W    = 32;  // 64-bit mode shared/private window span
  localparam int NAR_W    = 32;  // narrow pointer width
  localparam int HOLE_LSB = VA_W - 1;
  localparam int N_APE    = 4;

  typedef enum logic [1:0] {
    MD_GVM64 = 2'd0,
    MD_HSA64 = 2'd1,
    MD_HSA32 = 2'd2
  } mode_e;

  typedef enum logic [2:0] {
    RG_DFLT = 3'd0,
    RG_GVM  = 3'd1,
    RG_APE1 = 3'd2,
    RG_SHR  = 3'd3,
    RG_PRV  = 3'd4,
    RG_HOLE = 3'd5
  } region_e;

  typedef enum logic [1:0] {
    RT_GLOBAL  = 2'd0,
    RT_SHARED  = 2'd1,
    RT_PRIVATE = 2'd2
  } route_e;

  typedef struct packed {
    logic [PTR_W-1:0]        gv_lo;
    logic [PTR_W-1:0]        gv_hi;
    logic [PTR_W-1:0]        a1_lo;
    logic [PTR_W-1:0]        a1_hi;
    logic [PTR_W-WIN_W-1:0]  sh_w64;
    logic [NAR_W-GRAN_W-1:0] sh_w32;
    logic [PTR_W-WIN_W-1:0]  pv_w64;
    logic [NAR_W-GRAN_W-1:0] pv_w32;
  } apcfg_t;
endpackage

// File: rtl/fad_cfg_regs.sv
module fad_cfg_regs
  import fad_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [2:0]              waddr,
  input  logic [PTR_W-1:GRAN_W]   wdata,
  output apcfg_t                  cfg,
  output logic                    cfg_err
);
  localparam int RW = PTR_W - GRAN_W;

  logic [RW-1:0] gv_b, gv_l, a1_b, a1_l, sh_r, pv_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gv_b <= '1;
      gv_l <= '0;
      a1_b <= '1;
      a1_l <= '0;
      sh_r <= '0;
      pv_r <= '0;
    end else if (we) begin
      case (waddr)
        3'd0: gv_b <= wdata;
        3'd1: gv_l <= wdata;
        3'd2: a1_b <= wdata;
        3'd3: a1_l <= wdata;
        3'd4: sh_r <= wdata;
        3'd5: pv_r <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg.gv_lo  = {gv_b, {GRAN_W{1'b0}}};
    cfg.gv_hi  = {gv_l, {GRAN_W{1'b1}}};
    cfg.a1_lo  = {a1_b, {GRAN_W{1'b0}}};
    cfg.a1_hi  = {a1_l, {GRAN_W{1'b1}}};
    cfg.sh_w64 = sh_r[RW-1:WIN_W-GRAN_W];
    cfg.sh_w32 = sh_r[NAR_W-GRAN_W-1:0];
    cfg.pv_w64 = pv_r[RW-1:WIN_W-GRAN_W];
    cfg.pv_w32 = pv_r[NAR_W-GRAN_W-1:0];
  end

  // Window table used for the overlap scan: 0 shared, 1 private, 2 VM, 3 spare
  logic [PTR_W-1:0] w_lo [N_APE];
  logic [PTR_W-1:0] w_hi [N_APE];
  logic             w_en [N_APE];

  always_comb begin
    w_lo[0] = {cfg.sh_w64, {WIN_W{1'b0}}};
    w_hi[0] = {cfg.sh_w64, {WIN_W{1'b1}}};
    w_en[0] = |cfg.sh_w64;
    w_lo[1] = {cfg.pv_w64, {WIN_W{1'b0}}};
    w_hi[1] = {cfg.pv_w64, {WIN_W{1'b1}}};
    w_en[1] = |cfg.pv_w64;
    w_lo[2] = cfg.gv_lo;
    w_hi[2] = cfg.gv_hi;
    w_en[2] = cfg.gv_lo <= cfg.gv_hi;
    w_lo[3] = cfg.a1_lo;
    w_hi[3] = cfg.a1_hi;
    w_en[3] = cfg.a1_lo <= cfg.a1_hi;
  end

  logic overlap;
  always_comb begin
    overlap = 1'b0;
    for (int i = 0; i < N_APE; i++) begin
      for (int j = i + 1; j < N_APE; j++) begin
        if (w_en[i] && w_en[j] && (w_lo[i] <= w_hi[j]) && (w_lo[j] <= w_hi[i]))
          overlap = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_err <= 1'b0;
    else        cfg_err <= cfg_err | overlap;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err); // R11

  AST_SPARE_ADDR_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr > 3'd5) |=> $stable(cfg)); // R2
endmodule

// File: rtl/fad_region.sv
module fad_region
  import fad_pkg::*;
(
  input  mode_e            mode,
  input  logic [PTR_W-1:0] addr,
  input  apcfg_t           cfg,
  output region_e          rg
);
  logic                  narrow;
  logic [PTR_W-1:0]      ax;
  logic [PTR_W-1:HOLE_LSB] top;
  logic                  in_hole, sh_hit, pv_hit, gv_hit, a1_hit;

  always_comb begin
    narrow = (mode == MD_HSA32);
    ax     = narrow ? {{(PTR_W-NAR_W){1'b0}}, addr[NAR_W-1:0]} : addr;
    top    = addr[PTR_W-1:HOLE_LSB];
    in_hole = !narrow && !((&top) || !(|top));
    if (narrow) begin
      sh_hit = (|cfg.sh_w32) && (ax[NAR_W-1:GRAN_W] == cfg.sh_w32);
      pv_hit = (|cfg.pv_w32) && (ax[NAR_W-1:GRAN_W] == cfg.pv_w32);
    end else begin
      sh_hit = (|cfg.sh_w64) && (ax[PTR_W-1:WIN_W] == cfg.sh_w64);
      pv_hit = (|cfg.pv_w64) && (ax[PTR_W-1:WIN_W] == cfg.pv_w64);
    end
    gv_hit = (ax >= cfg.gv_lo) && (ax <= cfg.gv_hi);
    a1_hit = !narrow && (ax >= cfg.a1_lo) && (ax <= cfg.a1_hi);

    if (sh_hit)       rg = RG_SHR;
    else if (pv_hit)  rg = RG_PRV;
    else if (in_hole) rg = RG_HOLE;
    else if (gv_hit)  rg = RG_GVM;
    else if (a1_hit)  rg = RG_APE1;
    else              rg = RG_DFLT;
  end
endmodule

// File: rtl/flat_aperture_decoder.sv
module flat_aperture_decoder
  import fad_pkg::*;
#(
  parameter int OFS_W      = 4,
  parameter int MT_W       = 3,
  parameter int MTYPE_DFLT = 0,
  parameter int MTYPE_ALT  = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [2:0]            cfg_addr,
  input  logic [PTR_W-1:GRAN_W] cfg_wdata,
  output logic                  cfg_err,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [PTR_W-1:0]      req_ptr,
  input  logic [OFS_W-1:0]      req_last_ofs,
  input  logic                  req_compute,
  input  logic                  req_data_atc,
  input  logic                  req_ptr32,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [1:0]            rsp_route,
  output logic                  rsp_atc,
  output logic [VA_W-1:0]       rsp_vaddr,
  output logic [MT_W-1:0]       rsp_mtype,
  output logic                  rsp_viol
);
  localparam int NPROBE = 2;  // first byte, last byte

  apcfg_t cfg;

  fad_cfg_regs u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .waddr   (cfg_addr),
    .wdata   (cfg_wdata),
    .cfg     (cfg),
    .cfg_err (cfg_err)
  );

  mode_e mode;
  always_comb begin
    if (!req_compute || !req_data_atc) mode = MD_GVM64;
    else if (req_ptr32)                mode = MD_HSA32;
    else                               mode = MD_HSA64;
  end

  logic [PTR_W-1:0] probe [NPROBE];
  region_e          rg    [NPROBE];

  assign probe[0] = req_ptr;
  assign probe[1] = req_ptr + PTR_W'(req_last_ofs);

  for (genvar k = 0; k < NPROBE; k++) begin : g_probe
    fad_region u_rg (
      .mode (mode),
      .addr (probe[k]),
      .cfg  (cfg),
      .rg   (rg[k])
    );
  end

  logic            narrow, dflt_atc;
  logic [VA_W-1:0] px, base, va_n;
  logic [VA_W-1:0] sh_eff, pv_eff;
  route_e          route_n;
  logic            atc_n, viol_n;
  logic [MT_W-1:0] mt_n;

  always_comb begin
    narrow   = (mode == MD_HSA32);
    dflt_atc = (mode != MD_GVM64);
    px       = narrow ? {{(VA_W-NAR_W){1'b0}}, req_ptr[NAR_W-1:0]} : req_ptr[VA_W-1:0];
    sh_eff   = narrow ? {{(VA_W-NAR_W){1'b0}}, cfg.sh_w32, {GRAN_W{1'b0}}}
                      : {cfg.sh_w64[VA_W-WIN_W-1:0], {WIN_W{1'b0}}};
    pv_eff   = narrow ? {{(VA_W-NAR_W){1'b0}}, cfg.pv_w32, {GRAN_W{1'b0}}}
                      : {cfg.pv_w64[VA_W-WIN_W-1:0], {WIN_W{1'b0}}};
    route_n  = RT_GLOBAL;
    atc_n    = dflt_atc;
    base     = '0;
    mt_n     = MT_W'(MTYPE_DFLT);
    case (rg[0])
      RG_GVM: begin
        atc_n = 1'b0;
        base  = cfg.gv_lo[VA_W-1:0];
      end
      RG_APE1: mt_n = MT_W'(MTYPE_ALT);
      RG_SHR: begin
        route_n = RT_SHARED;
        atc_n   = 1'b0;
        base    = sh_eff;
      end
      RG_PRV: begin
        route_n = RT_PRIVATE;
        atc_n   = 1'b0;
        base    = pv_eff;
      end
      default: ;
    endcase
    va_n   = px - base;
    viol_n = (rg[0] == RG_HOLE) || (rg[0] != rg[1]);
  end

  logic accept;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_route <= '0;
      rsp_atc   <= 1'b0;
      rsp_vaddr <= '0;
      rsp_mtype <= '0;
      rsp_viol  <= 1'b0;
    end else begin
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_route <= route_n;
        rsp_atc   <= atc_n;
        rsp_vaddr <= va_n;
        rsp_mtype <= mt_n;
        rsp_viol  <= viol_n;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_route) && $stable(rsp_atc)
      && $stable(rsp_vaddr) && $stable(rsp_mtype) && $stable(rsp_viol))); // R10

  AST_DRAW_NO_ATC: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_compute) |=> !rsp_atc); // R1

  AST_NARROW_DFLT_MTYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_compute && req_data_atc && req_ptr32) |=> (rsp_mtype == MT_W'(MTYPE_DFLT))); // R6

  AST_HOLE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !(req_compute && req_data_atc && req_ptr32)
      && !((&req_ptr[PTR_W-1:HOLE_LSB]) || !(|req_ptr[PTR_W-1:HOLE_LSB])))
      |=> (rsp_viol || rsp_route != 2'd0)); // R3

  AST_LOCAL_NO_ATC: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_route != 2'd0) |-> !rsp_atc); // R9
endmodule

// File: tb/sim_flat_aperture_decoder.sv
`timescale 1ns/1ps
module sim_flat_aperture_decoder;
  localparam int OFS_W = 4;
  localparam int MT_W  = 3;
  localparam int MT_D  = 0;
  localparam int MT_A  = 5;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [2:0] cfg_addr = 0; logic [63:16] cfg_wdata = 0;
  logic cfg_err;
  logic req_valid = 0, req_ready;
  logic [63:0] req_ptr = 0; logic [OFS_W-1:0] req_last_ofs = 0;
  logic req_compute = 0, req_data_atc = 0, req_ptr32 = 0;
  logic rsp_valid, rsp_ready = 1;
  logic [1:0] rsp_route; logic rsp_atc; logic [47:0] rsp_vaddr;
  logic [MT_W-1:0] rsp_mtype; logic rsp_viol;

  always #10 clk = ~clk;

  flat_aperture_decoder #(.OFS_W(OFS_W), .MT_W(MT_W), .MTYPE_DFLT(MT_D), .MTYPE_ALT(MT_A)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_err(cfg_err), .req_valid(req_valid), .req_ready(req_ready), .req_ptr(req_ptr),
    .req_last_ofs(req_last_ofs), .req_compute(req_compute), .req_data_atc(req_data_atc),
    .req_ptr32(req_ptr32), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_route(rsp_route),
    .rsp_atc(rsp_atc), .rsp_vaddr(rsp_vaddr), .rsp_mtype(rsp_mtype), .rsp_viol(rsp_viol));

  int n_chk = 0, n_fail = 0;
  bit done = 0, bp_on = 0;
  string phase = "reset";

  // reference configuration (effective values)
  logic [63:0] m_glo = '1, m_ghi = 64'hFFFF, m_alo = '1, m_ahi = 64'hFFFF;
  logic [47:0] m_sh = 0, m_pv = 0;  // stored pointer bits 63:16
  bit m_err = 0;

  int          q_route[$]; bit q_atc[$]; logic [47:0] q_va[$]; int q_mt[$]; bit q_viol[$];
  bit          was_stall = 0;
  logic [53:0] held;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s (%s) actual=%h expected=%h", tag, phase, act, exp);
    end
  endtask

  function automatic int mode_of(bit comp, bit atc, bit p32);
    if (comp && atc) return p32 ? 2 : 1;
    return 0;
  endfunction

  // region codes: 0 default, 1 VM, 2 spare, 3 shared, 4 private, 5 hole
  function automatic int region_of(logic [63:0] a, int md);
    logic [63:0] p;
    logic [16:0] hi17;
    p = (md == 2) ? (a & 64'h0000_0000_FFFF_FFFF) : a;
    hi17 = a >> 47;
    if (md == 2) begin
      if (m_sh[15:0] != 0 && p[31:16] == m_sh[15:0]) return 3;
      if (m_pv[15:0] != 0 && p[31:16] == m_pv[15:0]) return 4;
    end else begin
      if (m_sh[47:16] != 0 && p[63:32] == m_sh[47:16]) return 3;
      if (m_pv[47:16] != 0 && p[63:32] == m_pv[47:16]) return 4;
      if (hi17 != 17'h0 && hi17 != 17'h1FFFF) return 5;
    end
    if (p >= m_glo && p <= m_ghi) return 1;
    if (md != 2 && p >= m_alo && p <= m_ahi) return 2;
    return 0;
  endfunction

  function automatic bit overlaps();
    logic [63:0] lo[4], hi[4]; bit en[4];
    lo[0] = {m_sh[47:16], 32'h0}; hi[0] = {m_sh[47:16], 32'hFFFF_FFFF}; en[0] = m_sh[47:16] != 0;
    lo[1] = {m_pv[47:16], 32'h0}; hi[1] = {m_pv[47:16], 32'hFFFF_FFFF}; en[1] = m_pv[47:16] != 0;
    lo[2] = m_glo; hi[2] = m_ghi; en[2] = m_glo <= m_ghi;
    lo[3] = m_alo; hi[3] = m_ahi; en[3] = m_alo <= m_ahi;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        if (i != j && en[i] && en[j] && lo[i] <= hi[j] && lo[j] <= hi[i]) return 1;
    return 0;
  endfunction

  task automatic predict();
    int md, r0, r1; logic [63:0] p, b; int rt; bit at; int mt;
    md = mode_of(req_compute, req_data_atc, req_ptr32);
    r0 = region_of(req_ptr, md);
    r1 = region_of(req_ptr + 64'(req_last_ofs), md);
    p = (md == 2) ? {32'h0, req_ptr[31:0]} : req_ptr;
    rt = 0; at = (md != 0); mt = MT_D; b = 0;
    if (r0 == 1) begin at = 0; b = m_glo; end
    if (r0 == 2) mt = MT_A;
    if (r0 == 3) begin rt = 1; at = 0; b = (md == 2) ? {32'h0, m_sh[15:0], 16'h0} : {m_sh[47:16], 32'h0}; end
    if (r0 == 4) begin rt = 2; at = 0; b = (md == 2) ? {32'h0, m_pv[15:0], 16'h0} : {m_pv[47:16], 32'h0}; end
    q_route.push_back(rt); q_atc.push_back(at); q_va.push_back(48'(p - b));
    q_mt.push_back(mt); q_viol.push_back(r0 == 5 || r0 != r1);
  endtask

  // monitor / reference, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cfg_err == m_err, "R11 cfg_err", 64'(cfg_err), 64'(m_err));
      if (was_stall)
        chk(rsp_valid && {rsp_route, rsp_atc, rsp_vaddr, rsp_mtype} == held, "R10 stall hold",
            64'({rsp_route, rsp_atc, rsp_vaddr, rsp_mtype}), 64'(held));
      chk(req_ready == (!rsp_valid || rsp_ready), "R10 req_ready", 64'(req_ready), 64'(!rsp_valid || rsp_ready));
      if (rsp_valid && rsp_ready) begin
        if (q_route.size() == 0) chk(0, "R10 unexpected result", 1, 0);
        else begin
          chk(rsp_route == 2'(q_route[0]), "R9 route", 64'(rsp_route), 64'(q_route[0]));
          chk(rsp_atc == q_atc[0], "R5 atc", 64'(rsp_atc), 64'(q_atc[0]));
          chk(rsp_vaddr == q_va[0], "R4 vaddr", 64'(rsp_vaddr), 64'(q_va[0]));
          chk(rsp_mtype == MT_W'(q_mt[0]), "R6 mtype", 64'(rsp_mtype), 64'(q_mt[0]));
          chk(rsp_viol == q_viol[0], "R7 viol", 64'(rsp_viol), 64'(q_viol[0]));
          void'(q_route.pop_front()); void'(q_atc.pop_front()); void'(q_va.pop_front());
          void'(q_mt.pop_front()); void'(q_viol.pop_front());
        end
      end
      was_stall = rsp_valid && !rsp_ready;
      held = {rsp_route, rsp_atc, rsp_vaddr, rsp_mtype};
      if (req_valid && req_ready) predict();
      m_err = m_err | overlaps();
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: m_glo = {cfg_wdata, 16'h0};
          3'd1: m_ghi = {cfg_wdata, 16'hFFFF};
          3'd2: m_alo = {cfg_wdata, 16'h0};
          3'd3: m_ahi = {cfg_wdata, 16'hFFFF};
          3'd4: m_sh = cfg_wdata;
          3'd5: m_pv = cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  initial begin
    rsp_ready = 1;
    forever begin
      @(posedge clk); #2;
      rsp_ready = bp_on ? ($urandom % 4 != 0) : 1'b1;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [63:0] v);
    cfg_we = 1; cfg_addr = a; cfg_wdata = v[63:16];
    @(posedge clk); #2;
    cfg_we = 0;
  endtask

  task automatic send(input logic [63:0] p, input int ofs, input bit comp, input bit atc, input bit p32);
    bit acc;
    req_valid = 1; req_ptr = p; req_last_ofs = OFS_W'(ofs);
    req_compute = comp; req_data_atc = atc; req_ptr32 = p32;
    do begin
      @(negedge clk); acc = req_ready;
      @(posedge clk); #2;
    end while (!acc);
    req_valid = 0;
  endtask

  task automatic drain();
    bp_on = 0;
    repeat (4) @(posedge clk);
    #2;
    chk(q_route.size() == 0, "R10 drained", 64'(q_route.size()), 0);
  endtask

  function automatic logic [63:0] pick();
    case ($urandom % 7)
      0: return 64'h0000_0100_0000_0000 + 64'($urandom % 64);
      1: return 64'h0000_01FF_FFFF_FFF0 + 64'($urandom % 32);
      2: return 64'hFFFF_8000_00FF_FFF0 + 64'($urandom % 32);
      3: return {16'h0002 + 16'($urandom % 2), 16'h0, 16'h0005 + 16'($urandom % 3), 16'($urandom)};
      4: return {16'h0001 + 16'($urandom % 4), 32'($urandom), 16'hFFF8 + 16'($urandom % 8)};
      5: return {32'($urandom), 32'($urandom)};
      default: return {16'hFFFF, 16'h8000, 16'h0000, 16'($urandom)};
    endcase
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1; n_chk++; n_fail++;
      $display("FAIL watchdog expired (%s) actual=1 expected=0", phase);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2; rst_n = 1;
    @(negedge clk);
    // R10 and R2: reset state
    chk(rsp_valid == 0, "R10 reset rsp_valid", 64'(rsp_valid), 0);
    chk(req_ready == 1, "R10 reset req_ready", 64'(req_ready), 1);
    chk(cfg_err == 0, "R2 reset cfg_err", 64'(cfg_err), 0);
    @(posedge clk); #2;

    phase = "R2 empty windows after reset";
    send(64'h0000_0000_0000_8000, 0, 0, 0, 0);
    send(64'h0000_0000_0000_8000, 0, 1, 1, 0);

    phase = "R1 mode decode";
    send(64'h0000_7000_0000_1000, 3, 1, 1, 0);
    send(64'h0000_7000_0000_1000, 3, 0, 1, 1);
    send(64'h0000_7000_0000_1000, 3, 1, 0, 1);
    send(64'h0000_7000_0000_1000, 3, 1, 1, 1);
    drain();

    wr(3'd0, 64'h0000_0100_0000_0000);
    wr(3'd1, 64'h0000_01FF_FFFF_0000);
    wr(3'd2, 64'hFFFF_8000_0000_0000);
    wr(3'd3, 64'hFFFF_8000_00FF_0000);
    wr(3'd4, 64'h0002_0000_0005_0000);
    wr(3'd5, 64'h0003_0000_0006_0000);
    wr(3'd6, 64'h0000_0100_0000_0000);  // R2: inert address
    wr(3'd7, 64'h0002_0000_0000_0000);

    phase = "R4 VM window and bounds";
    send(64'h0000_0100_0000_1234, 0, 1, 1, 0);
    send(64'h0000_0100_0000_0000, 0, 0, 0, 0);
    send(64'h0000_01FF_FFFF_FFFF, 0, 1, 1, 0);
    send(64'h0000_0200_0000_0000, 0, 1, 1, 0);
    send(64'h0000_00FF_FFFF_FFFF, 0, 0, 0, 0);
    phase = "R7 straddle";
    send(64'h0000_01FF_FFFF_FFFC, 4, 1, 1, 0);
    send(64'h0000_00FF_FFFF_FFF8, 15, 0, 0, 0);
    send(64'h0000_7FFF_FFFF_FFF8, 15, 1, 1, 0);
    phase = "R6 spare window";
    send(64'hFFFF_8000_0000_0040, 0, 1, 1, 0);
    send(64'hFFFF_8000_0000_0040, 0, 0, 0, 0);
    send(64'hFFFF_8000_0000_0040, 0, 1, 1, 1);
    phase = "R3 hole";
    send(64'h0001_0000_0000_0000, 0, 1, 1, 0);
    send(64'h8000_0000_0000_0000, 0, 0, 0, 0);
    send(64'h0001_0000_0000_0000, 0, 1, 1, 1);
    phase = "R9 shared and private 64-bit";
    send(64'h0002_0000_0000_0040, 0, 1, 1, 0);
    send(64'h0003_0000_FFFF_FFF0, 3, 0, 0, 0);
    send(64'h0002_0000_FFFF_FFFC, 7, 1, 1, 0);
    phase = "R8 narrow windows";
    send(64'hABCD_0000_0005_0010, 0, 1, 1, 1);
    send(64'h0000_0000_0006_FFFF, 0, 1, 1, 1);
    send(64'h0000_0000_0007_0000, 0, 1, 1, 1);
    send(64'h0000_0000_0005_FFFE, 3, 1, 1, 1);
    wr(3'd5, 64'h0003_0000_0000_0000);
    send(64'h0000_0000_0000_0100, 0, 1, 1, 1);
    wr(3'd5, 64'h0003_0000_0006_0000);
    drain();

    phase = "R10 random with back-pressure";
    bp_on = 1;
    for (int n = 0; n < 3000; n++) begin
      int sel;
      sel = $urandom % 4;
      send(pick(), int'($urandom % 16), sel != 0, sel > 1, sel == 3);
    end
    drain();

    phase = "R11 overlap and priority";
    wr(3'd2, 64'h0000_0180_0000_0000);
    wr(3'd3, 64'h0000_0180_00FF_0000);
    repeat (2) @(posedge clk);
    #2;
    send(64'h0000_0180_0000_0010, 0, 1, 1, 0);
    wr(3'd4, 64'h0000_0100_0000_0000);
    send(64'h0000_0100_0000_0020, 0, 1, 1, 0);
    wr(3'd2, 64'hFFFF_8000_0000_0000);
    wr(3'd3, 64'hFFFF_8000_00FF_0000);
    wr(3'd4, 64'h0002_0000_0005_0000);
    repeat (3) @(posedge clk);
    #2;
    drain();
    chk(cfg_err == 1, "R11 sticky after repair", 64'(cfg_err), 1);

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule